// File: doc/BRIEF.md
# Reconfiguration Controller Register Bank

This block is the software-visible face of an FPGA reconfiguration controller. A host writes and reads five 32-bit words over a plain single-cycle bus: a control word, a status word, two flash image base words (golden and multiboot) and a flash access word. The stored contents drive a configuration-port sequencer and a flash engine, both of which sit outside this block.

From the control word the host can ask the sequencer to read one of its internal configuration registers. The 16-bit result returns over a done strobe and is shown in the status word together with a valid flag. A full reprogram of the device is requested through the same word. It takes two writes: the first sets an unlock bit, and the second sets the start bit. A start bit written while the unlock bit is clear does nothing.

A watchdog counts cycles while the sequencer reports busy. If busy lasts too long, the watchdog pulses a reset to the sequencer and leaves a sticky flag in the status word, which software clears by writing 0 to that bit.

Top module: `reconf_regbank`

## Requirements
- R1: After reset, the control, status, golden base and multiboot base words read 0, and the flash access word reads 0x10000000. The outputs `cfg_rd_start`, `reprog_start` and `seq_rst` are 0.
- R2: Word selection uses `bus_addr[4:2]`: 0 is control, 1 is status, 2 is golden base, 3 is multiboot base and 4 is flash access. `bus_addr[1:0]` is ignored. Both base words are fully read/write. In the flash access word, bits [28:0] are read/write and bits [31:29] read 0. Words 5 to 7 read 0, and writes to them are ignored.
- R3: Control bits [5:0] are a read/write configuration register address, which is also driven on `cfg_rd_addr`.
- R4: A control write with bit 6 = 1 raises `cfg_rd_start` for exactly the one cycle after the write edge and clears the status valid bit (bit 16). A control write with bit 6 = 0 starts nothing. Bit 6 reads 0.
- R5: When `seq_done` is 1 at an edge, `seq_data` is latched into status bits [15:0] and status bit 16 is set.
- R6: Control bit 16 (unlock) is read/write and reads back the last value written to it, unless R7 clears it.
- R7: A control write with bit 17 = 1, made while unlock was already 1 before that write, raises `reprog_start` for one cycle after the write edge and clears unlock. If unlock was 0 before the write, no pulse is produced, even when the same write also sets bit 16. Bit 17 reads 0.
- R8: If `seq_busy` is 1 at `WDOG_LIMIT` consecutive edges, `seq_rst` is 1 for the one cycle after the last of those edges and status bit 17 becomes 1. A 0 on `seq_busy` at any edge restarts the count.
- R9: A status write with bit 17 = 0 clears the watchdog flag. A status write with bit 17 = 1 leaves it unchanged. Status bits [16:0] cannot be written.
- R10: Unimplemented control bits (7 to 15 and 18 to 31) read 0, and writing them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| cfg_rd_addr | output | 6 | Configuration register address for the sequencer |
| cfg_rd_start | output | 1 | One-cycle request to read a configuration register |
| reprog_start | output | 1 | One-cycle request to reprogram the device |
| seq_busy | input | 1 | Sequencer is busy |
| seq_done | input | 1 | Sequencer returns read data this cycle |
| seq_data | input | 16 | Configuration register image from the sequencer |
| seq_rst | output | 1 | One-cycle watchdog reset to the sequencer |
| gold_base | output | 32 | Golden image opcode [31:24] and flash address [23:0] |
| multi_base | output | 32 | Multiboot image opcode [31:24] and flash address [23:0] |
| flash_word | output | 32 | Flash access word, bits [31:29] always 0 |

## Verification
The assertions assume that `seq_done` arrives as a single-cycle strobe. They also assume that it does not coincide with a control write that starts a new read, because such a write takes priority over the strobe. The stimulus raises `seq_done` only in an idle cycle with no bus write. It keeps `seq_busy` low except in the watchdog tests, where the bench holds it for a counted number of edges. Bus writes last exactly one cycle.

// File: rtl/reconf_regbank.sv
module reconf_regbank #(
  parameter int WDOG_LIMIT = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [5:0]  cfg_rd_addr,
  output logic        cfg_rd_start,
  output logic        reprog_start,
  input  logic        seq_busy,
  input  logic        seq_done,
  input  logic [15:0] seq_data,
  output logic        seq_rst,
  output logic [31:0] gold_base,
  output logic [31:0] multi_base,
  output logic [31:0] flash_word
);
  localparam int          WD_W      = (WDOG_LIMIT > 1) ? $clog2(WDOG_LIMIT) : 1;
  localparam logic [31:0] FLASH_RST = 32'h1000_0000;
  localparam int          FLASH_W   = 29;

  logic [2:0]         word;
  logic               wr_ctrl, wr_stat, wr_gold, wr_multi, wr_flash;
  logic               rd_req, start_ok, wd_hit;
  logic               unlock, img_valid, wd_flag;
  logic [15:0]        img;
  logic [WD_W-1:0]    wd_cnt;
  logic [FLASH_W-1:0] flash_q;

  assign word     = bus_addr[4:2];
  assign wr_ctrl  = bus_wr && (word == 3'd0);
  assign wr_stat  = bus_wr && (word == 3'd1);
  assign wr_gold  = bus_wr && (word == 3'd2);
  assign wr_multi = bus_wr && (word == 3'd3);
  assign wr_flash = bus_wr && (word == 3'd4);
  assign rd_req   = wr_ctrl && bus_wdata[6];
  assign start_ok = wr_ctrl && bus_wdata[17] && unlock;
  assign wd_hit   = seq_busy && (wd_cnt == WD_W'(WDOG_LIMIT - 1));

  assign flash_word = {3'b000, flash_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rd_addr  <= '0;
      unlock       <= 1'b0;
      cfg_rd_start <= 1'b0;
      reprog_start <= 1'b0;
    end else begin
      cfg_rd_start <= rd_req;
      reprog_start <= start_ok;
      if (wr_ctrl) begin
        cfg_rd_addr <= bus_wdata[5:0];
        unlock      <= start_ok ? 1'b0 : bus_wdata[16];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      img       <= '0;
      img_valid <= 1'b0;
    end else begin
      if (seq_done) img <= seq_data;
      if (rd_req)        img_valid <= 1'b0;
      else if (seq_done) img_valid <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_cnt  <= '0;
      seq_rst <= 1'b0;
      wd_flag <= 1'b0;
    end else begin
      seq_rst <= wd_hit;
      if (!seq_busy || wd_hit) wd_cnt <= '0;
      else                     wd_cnt <= wd_cnt + 1'b1;
      if (wd_hit)                        wd_flag <= 1'b1;
      else if (wr_stat && !bus_wdata[17]) wd_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gold_base  <= '0;
      multi_base <= '0;
      flash_q    <= FLASH_RST[FLASH_W-1:0];
    end else begin
      if (wr_gold)  gold_base  <= bus_wdata;
      if (wr_multi) multi_base <= bus_wdata;
      if (wr_flash) flash_q    <= bus_wdata[FLASH_W-1:0];
    end
  end

  always_comb begin
    case (word)
      3'd0:    bus_rdata = {14'd0, 1'b0, unlock, 10'd0, cfg_rd_addr};
      3'd1:    bus_rdata = {14'd0, wd_flag, img_valid, img};
      3'd2:    bus_rdata = gold_base;
      3'd3:    bus_rdata = multi_base;
      3'd4:    bus_rdata = flash_word;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/reconf_regbank_chk.sv
module reconf_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [4:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        seq_done,
  input logic        cfg_rd_start,
  input logic        reprog_start,
  input logic        seq_rst,
  input logic        unlock,
  input logic        img_valid,
  input logic        wd_flag
);
  // R4
  cfg_rd_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_start |-> !img_valid);

  // R5
  done_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !(bus_wr && bus_addr[4:2] == 3'd0 && bus_wdata[6])) |=> img_valid);

  // R7
  reprog_needs_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reprog_start |-> ($past(unlock) && !unlock));

  // R7
  locked_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[4:2] == 3'd0 && bus_wdata[17] && !unlock) |=> !reprog_start);

  // R8
  wdog_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_rst |-> wd_flag);
endmodule

bind reconf_regbank reconf_regbank_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .seq_done     (seq_done),
  .cfg_rd_start (cfg_rd_start),
  .reprog_start (reprog_start),
  .seq_rst      (seq_rst),
  .unlock       (unlock),
  .img_valid    (img_valid),
  .wd_flag      (wd_flag)
);

// File: tb/test_reconf_regbank.sv
module test_reconf_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 24;
  localparam int NVEC       = 8;

  // {req, addr, wdata, expected read}
  localparam logic [76:0] VEC [NVEC] = '{
    {8'd2,  5'h08, 32'hDEADBEEF, 32'hDEADBEEF},  // R2
    {8'd2,  5'h0C, 32'h0B123456, 32'h0B123456},  // R2
    {8'd2,  5'h10, 32'hFFFFFFFF, 32'h1FFFFFFF},  // R2
    {8'd3,  5'h00, 32'h0000002A, 32'h0000002A},  // R3
    {8'd10, 5'h00, 32'hFFFDFFBF, 32'h0001003F},  // R10 R6
    {8'd2,  5'h14, 32'hFFFFFFFF, 32'h00000000},  // R2
    {8'd9,  5'h04, 32'h0001FFFF, 32'h00000000},  // R9
    {8'd2,  5'h09, 32'h12345678, 32'h12345678}   // R2
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  cfg_rd_addr;
  logic        cfg_rd_start, reprog_start, seq_rst;
  logic        seq_busy = 1'b0;
  logic        seq_done = 1'b0;
  logic [15:0] seq_data = '0;
  logic [31:0] gold_base, multi_base, flash_word;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reconf_regbank #(.WDOG_LIMIT(LIMIT)) i_reconf_regbank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_rd_addr(cfg_rd_addr),
    .cfg_rd_start(cfg_rd_start), .reprog_start(reprog_start),
    .seq_busy(seq_busy), .seq_done(seq_done), .seq_data(seq_data),
    .seq_rst(seq_rst), .gold_base(gold_base), .multi_base(multi_base),
    .flash_word(flash_word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'h00, d); chk("R1 ctrl", d, 32'h0);
    rd(5'h04, d); chk("R1 status", d, 32'h0);
    rd(5'h08, d); chk("R1 gold", d, 32'h0);
    rd(5'h0C, d); chk("R1 multi", d, 32'h0);
    rd(5'h10, d); chk("R1 flash", d, 32'h10000000);
    chk("R1 pulses", {29'd0, cfg_rd_start, reprog_start, seq_rst}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][68:64], VEC[i][63:32]);
      rd(VEC[i][68:64], d);
      chk($sformatf("R%0d vector %0d", VEC[i][76:69], i), d, VEC[i][31:0]);
    end
    chk("R2 gold port", gold_base, 32'h12345678);
    chk("R2 flash port", flash_word, 32'h1FFFFFFF);

    // R4 read request pulse
    wr(5'h00, 32'h00000045);
    chk("R4 start pulse", {31'd0, cfg_rd_start}, 32'h1);
    chk("R3 addr port", {26'd0, cfg_rd_addr}, 32'h5);
    rd(5'h00, d); chk("R4 bit6 reads 0", d, 32'h00000005);
    @(negedge clk);
    chk("R4 single cycle", {31'd0, cfg_rd_start}, 32'h0);

    // R5 data return
    seq_done = 1'b1; seq_data = 16'hA5C3;
    @(negedge clk);
    seq_done = 1'b0; seq_data = '0;
    rd(5'h04, d); chk("R5 image valid", d, 32'h0001A5C3);
    wr(5'h00, 32'h00000045);
    rd(5'h04, d); chk("R4 valid cleared", d, 32'h0000A5C3);

    // R7 unlock sequence
    wr(5'h00, 32'h0);
    wr(5'h00, 32'h00020000);
    chk("R7 locked no pulse", {31'd0, reprog_start}, 32'h0);
    wr(5'h00, 32'h00030000);
    chk("R7 same write no pulse", {31'd0, reprog_start}, 32'h0);
    rd(5'h00, d); chk("R6 unlock set", d, 32'h00010000);
    wr(5'h00, 32'h00020000);
    chk("R7 pulse", {31'd0, reprog_start}, 32'h1);
    rd(5'h00, d); chk("R7 unlock cleared", d, 32'h0);
    @(negedge clk);
    chk("R7 single cycle", {31'd0, reprog_start}, 32'h0);

    // R8 short busy does not fire
    seq_busy = 1'b1;
    repeat (LIMIT - 1) @(negedge clk);
    seq_busy = 1'b0;
    @(negedge clk);
    chk("R8 short busy", {31'd0, seq_rst}, 32'h0);
    seq_busy = 1'b1;
    for (int k = 1; k <= LIMIT; k++) begin
      @(negedge clk);
      if ((k == LIMIT) != seq_rst)
        chk($sformatf("R8 seq_rst at %0d", k), {31'd0, seq_rst}, {31'd0, k == LIMIT});
    end
    chk("R8 fired", {31'd0, seq_rst}, 32'h1);
    seq_busy = 1'b0;
    @(negedge clk);
    chk("R8 single cycle", {31'd0, seq_rst}, 32'h0);
    rd(5'h04, d); chk("R8 flag", d, 32'h0002A5C3);

    // R9 flag clear
    wr(5'h04, 32'h0002FFFF);
    rd(5'h04, d); chk("R9 write 1 keeps", d, 32'h0002A5C3);
    wr(5'h04, 32'h0);
    rd(5'h04, d); chk("R9 write 0 clears", d, 32'h0000A5C3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule